// File: doc/BRIEF.md
# SPI Master Transmit Engine with Programmable Chip-Select Setup Time

This block drives one SPI slave as the bus master. Software programs the serial clock rate, the clock polarity and phase, and an 8-bit setup count. It then writes a transmit word to start a transfer. Chip select goes active on the very clock edge that accepts the write. The first serial-clock edge is then held off by (setup + 2) system clocks. When the phase bit is 1, a further half serial-clock period is added before that first edge. The word goes out on MOSI MSB first while MISO is shifted in. Chip select is released half a serial-clock period after the last edge, and the received word lands in a receive buffer.

The receive buffer has two read addresses. The normal address returns the word together with the receive-full and overrun flags, and clears both flags. The mirror address returns the same word with a fixed tag in the upper half and leaves every flag as it was. This lets a debugger inspect traffic without disturbing the software that consumes it. The register port is a plain single-cycle bus. Reads are registered, so the data appears on the cycle after the read strobe. There is no back-pressure on the register port. A transmit write that arrives while a transfer is running is dropped, and software checks the busy bit first. A configuration write made during a transfer takes effect from the next transfer.

Register map (word addresses on `reg_addr`): 0 control, 1 setup count, 2 transmit data, 3 receive buffer, 4 receive mirror, 5 status.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sclk is 0. Control (address 0), setup (address 1) and status (address 5) read 0, and the mirror (address 4) reads 0x8000_0000.
- R2: A write to address 2 while idle drives spi_cs_n low on the same clock edge. With phase 0, the first spi_sclk edge follows (N+2) system clocks later, where N is setup[7:0].
- R3: With phase 1 (control bit 1), the first spi_sclk edge follows (N+2+H) system clocks after spi_cs_n falls.
- R4: Successive spi_sclk edges are H clocks apart, where H is control[15:8] and a value of 0 acts as 1. The idle level of spi_sclk equals control bit 0 (polarity).
- R5: Each transfer has 2×16 spi_sclk edges, and MOSI sends the transmit word MSB first. With phase 0, data is sampled on odd-numbered edges; with phase 1, on even-numbered edges. MOSI is stable at every sampling edge. MISO is captured on the same edges, and the received word equals the slave's word.
- R6: spi_cs_n rises H clocks after the last spi_sclk edge. Status bit 0 (busy) is 1 exactly while spi_cs_n is low.
- R7: A write to address 2 while busy is ignored: the word being sent is unchanged and no extra transfer follows.
- R8: A read of address 3 returns {14'b0, overrun, full, data[15:0]} with overrun at bit 17 and full at bit 16, and clears both flags. Status bits 1 and 2 mirror full and overrun.
- R9: A read of address 4 returns {16'h8000, data[15:0]} and leaves full and overrun unchanged.
- R10: A transfer that completes while full is already set sets overrun and overwrites the buffer.
- R11: When a transfer completes on the same edge as a read of address 3, the read returns the old word and flags. Afterwards full is 1, overrun is 0, and the buffer holds the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The one clash that matters is a transfer completion and a clearing read of the receive buffer landing on the same clock edge. The bench computes the length of the chip-select window from the setup count, the phase and the half period. It then issues the read on exactly the edge where chip select is due to rise. It judges the result by three things: the returned value must carry the previous word with full set, the flags that follow must show full without overrun, and the mirror must show the new word. Random configurations and words around the directed cases check the edge timing and data against bench-computed values.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BUS_W = 32;
  localparam logic [15:0] MIRROR_TAG = 16'h8000;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_SETUP  = 3'd1,
    A_TX     = 3'd2,
    A_RXBUF  = 3'd3,
    A_MIRROR = 3'd4,
    A_STATUS = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETUP,
    S_PAD,
    S_SHIFT
  } seq_state_e;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [7:0] half;
    logic [7:0] setup;
  } xfer_cfg_t;
endpackage

// File: rtl/spim_regfile.sv
module spim_regfile
  import spim_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [BUS_W-1:0]  reg_rdata,
  output xfer_cfg_t         cfg,
  output logic              tx_req,
  output logic [DATA_W-1:0] tx_word,
  input  logic              busy,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_word
);
  logic              cpol_q, cpha_q;
  logic [7:0]        half_q, setup_q;
  logic [DATA_W-1:0] rxbuf_q;
  logic              full_q, ovr_q;
  logic [15:0]       rx16;
  logic [BUS_W-1:0]  rd_mux;
  logic              rd_clear;

  assign rd_clear = reg_rd && (reg_addr == A_RXBUF);
  assign tx_req   = reg_wr && (reg_addr == A_TX);
  assign tx_word  = reg_wdata[DATA_W-1:0];

  always_comb begin
    cfg.cpol  = cpol_q;
    cfg.cpha  = cpha_q;
    cfg.half  = (half_q == 8'd0) ? 8'd1 : half_q;
    cfg.setup = setup_q;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      half_q  <= 8'd0;
      setup_q <= 8'd0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        cpol_q <= reg_wdata[0];
        cpha_q <= reg_wdata[1];
        half_q <= reg_wdata[15:8];
      end
      if (reg_wr && reg_addr == A_SETUP) setup_q <= reg_wdata[7:0];
    end
  end

  // receive buffer and flags; completion wins over a same-edge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf_q <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (rx_done) begin
      rxbuf_q <= rx_word;
      full_q  <= 1'b1;
      ovr_q   <= rd_clear ? 1'b0 : (ovr_q | full_q);
    end else if (rd_clear) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assign rx16 = 16'(rxbuf_q);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:   rd_mux = {16'd0, half_q, 6'd0, cpha_q, cpol_q};
      A_SETUP:  rd_mux = {24'd0, setup_q};
      A_RXBUF:  rd_mux = {14'd0, ovr_q, full_q, rx16};
      A_MIRROR: rd_mux = {MIRROR_TAG, rx16};
      A_STATUS: rd_mux = {29'd0, ovr_q, full_q, busy};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_MIRROR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_MIRROR && !rx_done) |=> ($stable(full_q) && $stable(ovr_q))); // R9
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && full_q && !rd_clear) |=> ovr_q); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !rx_done) |=> (!full_q && !ovr_q)); // R8
  AST_COLLIDE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && rx_done) |=> (full_q && !ovr_q)); // R11
endmodule

// File: rtl/spim_sequencer.sv
module spim_sequencer
  import spim_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  xfer_cfg_t       cfg,
  input  logic            tx_req,
  output logic            busy,
  output logic            cs_n,
  output logic            load,
  output logic            tog,
  output logic [$clog2(2*DATA_W+1)-1:0] edge_k,
  output logic            done,
  output logic            cpol_l,
  output logic            cpha_l
);
  localparam int EW    = $clog2(2*DATA_W+1);
  localparam int NEDGE = 2 * DATA_W;
  localparam int CW    = 9;
  localparam int AW    = 10;

  seq_state_e     st_q;
  logic [CW-1:0]  cnt_q;
  logic [EW-1:0]  edges_q;
  logic [7:0]     half_l, setup_l;
  logic           last_edge, cnt_zero;
  logic [AW-1:0]  age_q;

  assign busy      = (st_q != S_IDLE);
  assign cs_n      = (st_q == S_IDLE);
  assign load      = (st_q == S_IDLE) && tx_req;
  assign cnt_zero  = (cnt_q == '0);
  assign last_edge = (edges_q == EW'(NEDGE));
  assign done      = (st_q == S_SHIFT) && cnt_zero && last_edge;
  assign tog       = cnt_zero && (((st_q == S_SETUP) && !cpha_l) ||
                                  (st_q == S_PAD) ||
                                  ((st_q == S_SHIFT) && !last_edge));
  assign edge_k    = (st_q == S_SHIFT) ? edges_q + EW'(1) : EW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      edges_q <= '0;
      half_l  <= 8'd1;
      setup_l <= 8'd0;
      cpol_l  <= 1'b0;
      cpha_l  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (tx_req) begin
          st_q    <= S_SETUP;
          cnt_q   <= {1'b0, cfg.setup} + CW'(1);
          edges_q <= '0;
          half_l  <= cfg.half;
          setup_l <= cfg.setup;
          cpol_l  <= cfg.cpol;
          cpha_l  <= cfg.cpha;
        end
        S_SETUP: if (cnt_zero) begin
          cnt_q <= CW'(half_l) - CW'(1);
          if (cpha_l) st_q <= S_PAD;
          else begin
            st_q    <= S_SHIFT;
            edges_q <= EW'(1);
          end
        end else cnt_q <= cnt_q - CW'(1);
        S_PAD: if (cnt_zero) begin
          st_q    <= S_SHIFT;
          edges_q <= EW'(1);
          cnt_q   <= CW'(half_l) - CW'(1);
        end else cnt_q <= cnt_q - CW'(1);
        S_SHIFT: if (cnt_zero) begin
          if (last_edge) st_q <= S_IDLE;
          else begin
            edges_q <= edges_q + EW'(1);
            cnt_q   <= CW'(half_l) - CW'(1);
          end
        end else cnt_q <= cnt_q - CW'(1);
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // checker counter: cycles since chip select went active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= '0;
    else if (st_q == S_IDLE)  age_q <= '0;
    else if (age_q != '1)     age_q <= age_q + AW'(1);
  end

  AST_SETUP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (tog && edge_k == EW'(1)) |->
      (age_q == AW'(setup_l) + AW'(1) + (cpha_l ? AW'(half_l) : AW'(0)))); // R2 R3
  AST_START_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_req)); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R6
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tog,
  input  logic [$clog2(2*DATA_W+1)-1:0] edge_k,
  input  logic              cpha_l,
  input  logic              cpol_l,
  input  logic              cpol_live,
  input  logic              busy,
  input  logic              miso,
  output logic              mosi,
  output logic              sclk,
  output logic [DATA_W-1:0] rx_word
);
  localparam int EW = $clog2(2*DATA_W+1);

  logic [DATA_W-1:0] txsh_q, rxsh_q;
  logic              phase_q;
  logic              smp_edge, first_lead;

  assign smp_edge   = cpha_l ? !edge_k[0] : edge_k[0];
  assign first_lead = cpha_l && (edge_k == EW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh_q  <= '0;
      rxsh_q  <= '0;
      phase_q <= 1'b0;
    end else if (load) begin
      txsh_q  <= tx_word;
      phase_q <= 1'b0;
    end else if (tog) begin
      phase_q <= ~phase_q;
      if (smp_edge)         rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
      else if (!first_lead) txsh_q <= {txsh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign mosi    = txsh_q[DATA_W-1];
  assign sclk    = (busy ? cpol_l : cpol_live) ^ phase_q;
  assign rx_word = rxsh_q;

  AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !phase_q); // R4
  AST_MOSI_STABLE_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tog && smp_edge) |=> $stable(mosi)); // R5
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int EW = $clog2(2*DATA_W+1);

  xfer_cfg_t         cfg;
  logic              tx_req, busy, load, tog, done, cpol_l, cpha_l;
  logic [EW-1:0]     edge_k;
  logic [DATA_W-1:0] tx_word, rx_word;

  spim_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cfg(cfg), .tx_req(tx_req), .tx_word(tx_word), .busy(busy),
    .rx_done(done), .rx_word(rx_word)
  );

  spim_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tx_req(tx_req), .busy(busy),
    .cs_n(spi_cs_n), .load(load), .tog(tog), .edge_k(edge_k), .done(done),
    .cpol_l(cpol_l), .cpha_l(cpha_l)
  );

  spim_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .tx_word(tx_word), .tog(tog),
    .edge_k(edge_k), .cpha_l(cpha_l), .cpol_l(cpol_l), .cpol_live(cfg.cpol),
    .busy(busy), .miso(spi_miso), .mosi(spi_mosi), .sclk(spi_sclk),
    .rx_word(rx_word)
  );

  AST_BUSY_MATCHES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !spi_cs_n); // R6
endmodule

// File: tb/spi_cs_master_bench.sv
`timescale 1ns/1ps
module spi_cs_master_bench;
  localparam int CLK_P = 10;
  localparam int W     = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // bench-side receive model
  bit          exp_full = 0, exp_ovr = 0;
  logic [15:0] exp_buf = '0;

  // line monitor state
  time         t_csf, t_first, t_last, t_csr;
  int          ek = 0, cur_h = 1;
  bit          cpha_cur = 0, int_bad = 0;
  logic [15:0] mcap = '0, sw_word = '0;
  int          cur_n = 0;
  logic [15:0] cur_tx = '0;
  bit          cur_pol = 0;

  spi_cs_master #(.DATA_W(W)) u_spi_cs_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge spi_cs_n) begin
    t_csf = $time; ek = 0; mcap = '0; int_bad = 0;
    spi_miso = sw_word[15];
  end
  always @(posedge spi_cs_n) t_csr = $time;

  always @(spi_sclk) begin
    if (!spi_cs_n) begin
      int idx;
      ek++;
      if (ek == 1) t_first = $time;
      else if (($time - t_last) != time'(cur_h * CLK_P)) int_bad = 1;
      t_last = $time;
      if (cpha_cur ? (ek % 2 == 0) : (ek % 2 == 1)) mcap = {mcap[14:0], spi_mosi};
      else begin
        idx = cpha_cur ? (ek - 1) / 2 : ek / 2;
        if (idx < 16) spi_miso = sw_word[15 - idx];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic int heff(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  function automatic int win_len(input int n, input int h, input bit cpha);
    return n + 2 + (cpha ? heff(h) : 0) + 2 * W * heff(h);
  endfunction

  task automatic xfer_start(input bit pol, input bit pha, input int h, input int n,
                            input logic [15:0] tx, input logic [15:0] sw);
    cur_h = heff(h); cpha_cur = pha; sw_word = sw; cur_n = n; cur_tx = tx; cur_pol = pol;
    wr(3'd0, {16'd0, 8'(h), 6'd0, pha, pol});
    wr(3'd1, 32'(n));
    chk(spi_sclk == pol, "R4 idle level", 32'(spi_sclk), 32'(pol));
    wr(3'd2, 32'(tx));
  endtask

  task automatic xfer_finish(input bit collided);
    logic [31:0] d;
    if (!spi_cs_n) @(posedge spi_cs_n);
    #1;
    chk((t_first - t_csf) == time'((cur_n + 2 + (cpha_cur ? cur_h : 0)) * CLK_P),
        cpha_cur ? "R3 phase-1 setup" : "R2 setup delay",
        32'((t_first - t_csf) / CLK_P), 32'(cur_n + 2 + (cpha_cur ? cur_h : 0)));
    chk(!int_bad, "R4 edge spacing", 32'(int_bad), 32'd0);
    chk(ek == 2 * W, "R5 edge count", 32'(ek), 32'(2 * W));
    chk(mcap == cur_tx, "R5 mosi word", 32'(mcap), 32'(cur_tx));
    chk((t_csr - t_last) == time'(cur_h * CLK_P), "R6 cs tail",
        32'((t_csr - t_last) / CLK_P), 32'(cur_h));
    chk(spi_sclk == cur_pol, "R4 sclk returns idle", 32'(spi_sclk), 32'(cur_pol));
    if (collided) exp_ovr = 0; else exp_ovr = exp_ovr | exp_full;
    exp_full = 1; exp_buf = sw_word;
    rd(3'd4, d);
    chk(d == {16'h8000, exp_buf}, "R5 R9 mirror data", d, {16'h8000, exp_buf});
    rd(3'd5, d);
    chk(d == {29'd0, exp_ovr, exp_full, 1'b0}, "R9 R10 flags after mirror", d,
        {29'd0, exp_ovr, exp_full, 1'b0});
  endtask

  task automatic read_clear();
    logic [31:0] d;
    rd(3'd3, d);
    chk(d == {14'd0, exp_ovr, exp_full, exp_buf}, "R8 rxbuf read", d,
        {14'd0, exp_ovr, exp_full, exp_buf});
    exp_full = 0; exp_ovr = 0;
    rd(3'd5, d);
    chk(d == 32'd0, "R8 flags cleared", d, 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1 cs idle", 32'(spi_cs_n), 32'd1);
    chk(spi_sclk == 1'b0, "R1 sclk idle", 32'(spi_sclk), 32'd0);
    rd(3'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(3'd1, d); chk(d == 0, "R1 setup", d, 0);
    rd(3'd5, d); chk(d == 0, "R1 status", d, 0);
    rd(3'd4, d); chk(d == 32'h8000_0000, "R1 mirror", d, 32'h8000_0000);

    // directed: minimum setup, nominal setup, maximum setup, half of 0
    xfer_start(0, 0, 1, 0, 16'hA5C3, 16'h3C5A); xfer_finish(0);
    read_clear();
    xfer_start(0, 0, 2, 7, 16'h8001, 16'hFFFE); xfer_finish(0);
    read_clear();
    xfer_start(1, 1, 3, 255, 16'h1234, 16'hBEEF); xfer_finish(0);
    read_clear();
    xfer_start(1, 0, 0, 1, 16'h7FFE, 16'h0001); xfer_finish(0);
    read_clear();
    xfer_start(0, 1, 0, 0, 16'hFFFF, 16'h0000); xfer_finish(0);

    // R10 overrun: second completion while full
    xfer_start(1, 1, 1, 3, 16'h0F0F, 16'hC001); xfer_finish(0);
    chk(exp_ovr == 1, "R10 model overrun", 32'(exp_ovr), 1);
    read_clear();

    // R7 write while busy is dropped, R6 busy bit
    xfer_start(0, 0, 2, 4, 16'hC3A5, 16'h5A5A);
    repeat (10) @(posedge clk);
    rd(3'd5, d); chk(d[0] == 1'b1, "R6 busy during transfer", d, 32'd1);
    wr(3'd2, 32'h0000_1111);
    xfer_finish(0);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R7 no extra transfer", 32'(spi_cs_n), 32'd1);
    rd(3'd5, d); chk(d[0] == 1'b0, "R6 busy clear after", d, 32'd0);
    read_clear();

    // R11 completion and clearing read on the same edge
    xfer_start(0, 1, 2, 5, 16'h2468, 16'h1357); xfer_finish(0);
    xfer_start(1, 1, 2, 9, 16'h9ABC, 16'hDEF0);
    repeat (win_len(9, 2, 1) - 1) @(posedge clk);
    rd(3'd3, d);
    chk(d == {14'd0, 1'b0, 1'b1, 16'h1357}, "R11 read returns old word", d,
        {14'd0, 1'b0, 1'b1, 16'h1357});
    chk(spi_cs_n == 1'b1, "R11 transfer ended at read edge", 32'(spi_cs_n), 32'd1);
    xfer_finish(1);
    read_clear();

    // constrained random transfers
    for (int i = 0; i < 24; i++) begin
      int n, h;
      bit pol, pha;
      n   = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 8);
      h   = int'($urandom % 5);
      pol = 1'($urandom);
      pha = 1'($urandom);
      xfer_start(pol, pha, h, n, 16'($urandom), 16'($urandom));
      xfer_finish(0);
      if ($urandom % 3 == 0) read_clear();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule